// File: doc/BRIEF.md
# Write burst splitter

This block turns one incrementing or fixed write burst of 32-bit words into an ordered series of commands for a simpler target bus. The target bus takes single transfers with any set of byte lanes. It also takes bursts of at most 16 words, but only when every byte lane of every beat is enabled. Both burst kinds are split the same way. The block receives the start address, the beat count and the byte strobes of the first and the last beat. From these it issues single and burst commands, each with its own address, a burst flag and an encoded length.

The beats are split into three parts. A head single covers the first beat when that beat has a partial strobe. A body of full-lane bursts covers the middle beats, with each burst holding at most 16 beats. A tail single covers the last beat when that beat has a partial strobe. Each command waits for a valid/ready acknowledgement before the next one appears. A new burst is accepted only after the final command of the current one has been acknowledged. The data path and the write response are handled elsewhere.

Top module: `wr_burst_splitter`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `cmd_valid` is 0.
- R2: A burst with `req_len` = 0 (one beat) gives exactly one single command (`cmd_burst` = 0). Its address is `req_addr` with bits [1:0] replaced by the index of the lowest set bit of `req_first_strb`, or 0 when no bit is set.
- R3: In a burst of two or more beats whose first strobe is not 4'b1111, the first command is a single. Its address has the low-bit rule of R2.
- R4: In a burst of two or more beats whose last strobe is not 4'b1111, the final command is a single.
- R5: The remaining middle beats go out as bursts (`cmd_burst` = 1). Each burst has `cmd_blen` = beats − 1 and address bits [1:0] = 0.
- R6: A middle section, or a remainder after 16-beat cuts, of exactly one beat is sent as a single and never as a one-beat burst.
- R7: The command after a single has the single's address plus 4, with bits [1:0] cleared.
- R8: The command after a burst has the burst's address plus 4 × (`cmd_blen` + 1).
- R9: A burst of 2 to 16 beats produces at most three commands. The only orders are single+single, single+single+single, single+burst+single, single+burst, burst+single and burst alone.
- R10: While `cmd_valid` = 1 and `cmd_ready` = 0, the command fields stay unchanged. The next command, if there is one, appears in the cycle after the acknowledgement.
- R11: `req_ready` goes to 0 in the cycle after a burst is accepted. It returns to 1 in the cycle after the last command is acknowledged. A `req_valid` seen while `req_ready` = 0 has no effect.
- R12: A body longer than 16 beats, up to 256 in total, is cut into consecutive 16-beat bursts followed by the remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Block idle and able to take a burst |
| req_addr | input | ADDR_W | Start byte address of the burst |
| req_len | input | LEN_W | Beat count minus one |
| req_first_strb | input | 4 | Byte strobes of the first beat |
| req_last_strb | input | 4 | Byte strobes of the last beat |
| cmd_valid | output | 1 | Target command present |
| cmd_ready | input | 1 | Target accepts the command |
| cmd_addr | output | ADDR_W | Command byte address |
| cmd_burst | output | 1 | 1 = burst, 0 = single |
| cmd_blen | output | log2(MAX_BURST) | Burst beats minus one; 0 for a single |

## Verification
The hardest situation to reach is a command series that crosses a 16-beat cut, has a partial head and a partial tail, and is held up by a stalled target at the same time. In that case the address advance after a burst, the one-beat remainder rule and the hold-while-stalled rule all act within one burst. The stimulus table includes bursts of 17, 18, 20 and 256 beats with mixed edge strobes. The bench holds `cmd_ready` low on alternate commands, and during those stalls it also presents a new burst request that must be ignored. A reset asserted in the middle of the 256-beat series checks that the block returns to idle.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    localparam int STRB_W = 4;
    localparam int LANE_W = $clog2(STRB_W);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HEAD = 2'd1,
        SRC_BODY = 2'd2,
        SRC_TAIL = 2'd3
    } piece_src_e;
endpackage

// File: rtl/wbs_plan.sv
// Splits a request into head single, body beat count and tail single.
module wbs_plan
    import wbs_pkg::*;
#(
    parameter int LEN_W = 8,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [STRB_W-1:0] first_strb,
    input  logic [STRB_W-1:0] last_strb,
    output logic              head_single,
    output logic              tail_single,
    output logic [CNT_W-1:0]  body_beats,
    output logic [LANE_W-1:0] lane_off
);
    localparam logic [STRB_W-1:0] FULL = '1;

    logic [CNT_W-1:0] total_beats;
    logic [STRB_W-1:0] lane_hit;

    assign total_beats = {1'b0, len} + CNT_W'(1);

    // one lane-select term per byte lane: set only for the lowest asserted lane
    for (genvar g = 0; g < STRB_W; g++) begin : g_lane
        if (g == 0) begin : g_first
            assign lane_hit[g] = first_strb[g];
        end else begin : g_rest
            assign lane_hit[g] = first_strb[g] && (first_strb[g-1:0] == '0);
        end
    end

    always_comb begin
        lane_off = '0;
        for (int i = 0; i < STRB_W; i++) begin
            if (lane_hit[i]) lane_off = LANE_W'(i);
        end
    end

    always_comb begin
        if (len == '0) begin
            head_single = 1'b1;
            tail_single = 1'b0;
            body_beats  = '0;
        end else begin
            head_single = (first_strb != FULL);
            tail_single = (last_strb != FULL);
            body_beats  = total_beats - CNT_W'(head_single) - CNT_W'(tail_single);
        end
    end
endmodule

// File: rtl/wbs_piece.sv
// Chooses the next command piece from the pending work.
module wbs_piece
    import wbs_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int MAX_BURST = 16,
    localparam int BLEN_W   = $clog2(MAX_BURST)
) (
    input  logic              head_pend,
    input  logic              tail_pend,
    input  logic [CNT_W-1:0]  body_rem,
    output piece_src_e        src,
    output logic              is_burst,
    output logic [BLEN_W-1:0] blen,
    output logic [CNT_W-1:0]  beats
);
    logic [CNT_W-1:0] chunk;

    assign chunk = (body_rem > CNT_W'(MAX_BURST)) ? CNT_W'(MAX_BURST) : body_rem;

    always_comb begin
        src      = SRC_NONE;
        is_burst = 1'b0;
        blen     = '0;
        beats    = CNT_W'(1);
        if (head_pend) begin
            src = SRC_HEAD;
        end else if (body_rem != '0) begin
            src   = SRC_BODY;
            beats = chunk;
            if (chunk != CNT_W'(1)) begin
                is_burst = 1'b1;
                blen     = BLEN_W'(chunk - CNT_W'(1));
            end
        end else if (tail_pend) begin
            src = SRC_TAIL;
        end
    end
endmodule

// File: rtl/wbs_addr_step.sv
// Address of the piece that follows the current one.
module wbs_addr_step #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 9
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              is_burst,
    input  logic [CNT_W-1:0]  beats,
    output logic [ADDR_W-1:0] next_addr
);
    always_comb begin
        if (is_burst) begin
            next_addr = cur_addr + (ADDR_W'(beats) << 2);
        end else begin
            next_addr = {cur_addr[ADDR_W-1:2] + (ADDR_W-2)'(1), 2'b00};
        end
    end
endmodule

// File: rtl/wr_burst_splitter.sv
module wr_burst_splitter
    import wbs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 8,
    parameter int MAX_BURST = 16,
    localparam int CNT_W    = LEN_W + 1,
    localparam int BLEN_W   = $clog2(MAX_BURST)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [STRB_W-1:0] req_first_strb,
    input  logic [STRB_W-1:0] req_last_strb,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_burst,
    output logic [BLEN_W-1:0] cmd_blen
);
    typedef struct packed {
        logic              busy;
        logic              head;
        logic              tail;
        logic [CNT_W-1:0]  body;
        logic [ADDR_W-1:0] addr;
    } split_st_t;

    split_st_t st_d, st_q;

    logic              pl_head, pl_tail;
    logic [CNT_W-1:0]  pl_body;
    logic [LANE_W-1:0] pl_off;

    piece_src_e        pc_src;
    logic              pc_burst;
    logic [BLEN_W-1:0] pc_blen;
    logic [CNT_W-1:0]  pc_beats;
    logic [ADDR_W-1:0] step_addr;

    wbs_plan #(.LEN_W(LEN_W)) plan_i (
        .len         (req_len),
        .first_strb  (req_first_strb),
        .last_strb   (req_last_strb),
        .head_single (pl_head),
        .tail_single (pl_tail),
        .body_beats  (pl_body),
        .lane_off    (pl_off)
    );

    wbs_piece #(.CNT_W(CNT_W), .MAX_BURST(MAX_BURST)) piece_i (
        .head_pend (st_q.head),
        .tail_pend (st_q.tail),
        .body_rem  (st_q.body),
        .src       (pc_src),
        .is_burst  (pc_burst),
        .blen      (pc_blen),
        .beats     (pc_beats)
    );

    wbs_addr_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) step_i (
        .cur_addr  (st_q.addr),
        .is_burst  (pc_burst),
        .beats     (pc_beats),
        .next_addr (step_addr)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy = 1'b1;
                st_d.head = pl_head;
                st_d.tail = pl_tail;
                st_d.body = pl_body;
                st_d.addr = pl_head ? {req_addr[ADDR_W-1:2], pl_off}
                                    : {req_addr[ADDR_W-1:2], 2'b00};
            end
        end else if (cmd_ready) begin
            st_d.addr = step_addr;
            case (pc_src)
                SRC_HEAD: st_d.head = 1'b0;
                SRC_BODY: st_d.body = st_q.body - pc_beats;
                SRC_TAIL: st_d.tail = 1'b0;
                default:  st_d.body = st_q.body;
            endcase
            st_d.busy = st_d.head || st_d.tail || (st_d.body != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = !st_q.busy;
    assign cmd_valid = st_q.busy;
    assign cmd_addr  = st_q.addr;
    assign cmd_burst = pc_burst;
    assign cmd_blen  = pc_blen;
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int BLEN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LEN_W-1:0]  req_len,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_burst,
    input logic [BLEN_W-1:0] cmd_blen
);
    logic [7:0] pieces_q;
    logic       short_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pieces_q <= '0;
            short_q  <= 1'b0;
        end else if (req_valid && req_ready) begin
            pieces_q <= '0;
            short_q  <= (req_len < LEN_W'(16));
        end else if (cmd_valid && cmd_ready) begin
            pieces_q <= pieces_q + 8'd1;
        end
    end

    // R10
    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                       && $stable(cmd_burst) && $stable(cmd_blen)));

    // R5
    a_r5_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_burst) |-> (cmd_addr[1:0] == 2'b00));

    // R6
    a_r6_no_single_beat_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_burst) |-> (cmd_blen != '0));

    // R11
    a_r11_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_valid && !req_ready));

    // R7
    a_r7_after_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_burst) |=>
            (!cmd_valid || cmd_addr == {$past(cmd_addr[ADDR_W-1:2]) + (ADDR_W-2)'(1), 2'b00}));

    // R8
    a_r8_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_burst) |=>
            (!cmd_valid || cmd_addr == $past(cmd_addr)
                + ((ADDR_W'($past(cmd_blen)) + ADDR_W'(1)) << 2)));

    // R9
    a_r9_three_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && short_q) |-> (pieces_q < 8'd3));
endmodule

bind wr_burst_splitter wbs_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .BLEN_W (BLEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_len   (req_len),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_burst (cmd_burst),
    .cmd_blen  (cmd_blen)
);

// File: tb/wr_burst_splitter_tb_top.sv
`timescale 1ns/1ps
module wr_burst_splitter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [3:0]  req_first_strb = '0;
    logic [3:0]  req_last_strb = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic        cmd_burst;
    logic [3:0]  cmd_blen;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wr_burst_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .req_first_strb(req_first_strb), .req_last_strb(req_last_strb),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst), .cmd_blen(cmd_blen)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  len;
        logic [3:0]  fs;
        logic [3:0]  ls;
        logic [7:0]  n;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h1000_0000, 8'd0,   4'b0100, 4'b0100, 8'd1},  // R2 single beat, lane 2
        '{32'h0000_2000, 8'd0,   4'b1000, 4'b1000, 8'd1},  // R2 lane 3
        '{32'h0000_3000, 8'd1,   4'b1100, 4'b0011, 8'd2},  // R3 R4 R9 single+single
        '{32'h0000_5000, 8'd2,   4'b1110, 4'b0001, 8'd3},  // R6 R9 three singles
        '{32'h0000_6000, 8'd7,   4'b1000, 4'b1111, 8'd2},  // R3 R7 single+burst
        '{32'h0000_7000, 8'd7,   4'b1111, 4'b0111, 8'd2},  // R4 R8 burst+single
        '{32'h0000_8000, 8'd15,  4'b1111, 4'b1111, 8'd1},  // R5 burst of 16
        '{32'h0000_4003, 8'd15,  4'b0010, 4'b0100, 8'd3},  // R3 R9 single+burst+single
        '{32'h0000_9000, 8'd1,   4'b1111, 4'b1111, 8'd1},  // R5 two-beat burst
        '{32'h0000_A000, 8'd16,  4'b1111, 4'b1111, 8'd2},  // R12 R6 burst16+single
        '{32'h0001_0000, 8'd255, 4'b1111, 4'b1111, 8'd16}, // R12 sixteen bursts
        '{32'h0000_C000, 8'd19,  4'b0001, 4'b1000, 8'd4},  // R12 s,b16,b2,s
        '{32'h0000_D000, 8'd17,  4'b0110, 4'b1111, 8'd3},  // R6 R12 s,b16,s
        '{32'h0000_E002, 8'd0,   4'b0000, 4'b0000, 8'd1}   // R2 no lane set
    };

    logic [31:0] m_addr  [32];
    logic        m_burst [32];
    logic [3:0]  m_blen  [32];
    int          m_n;

    function automatic logic [1:0] low_lane(input logic [3:0] s);
        for (int i = 0; i < 4; i++) if (s[i]) return 2'(i);
        return 2'd0;
    endfunction

    // expected command list from the requirements
    task automatic build_model(input vec_t v);
        logic [31:0] cur;
        int mid, c;
        bit hd, tl;
        m_n = 0;
        if (v.len == 0) begin
            m_addr[0] = {v.addr[31:2], low_lane(v.fs)};
            m_burst[0] = 1'b0; m_blen[0] = 4'd0; m_n = 1;
            return;
        end
        hd = (v.fs != 4'hF);
        tl = (v.ls != 4'hF);
        mid = int'(v.len) + 1 - int'(hd) - int'(tl);
        cur = {v.addr[31:2], 2'b00};
        if (hd) begin
            m_addr[m_n] = {v.addr[31:2], low_lane(v.fs)};
            m_burst[m_n] = 1'b0; m_blen[m_n] = 4'd0; m_n++;
            cur = cur + 32'd4;
        end
        while (mid > 0) begin
            c = (mid > 16) ? 16 : mid;
            m_addr[m_n] = cur;
            m_burst[m_n] = (c != 1);
            m_blen[m_n] = (c != 1) ? 4'(c - 1) : 4'd0;
            m_n++;
            cur = cur + 32'(4 * c);
            mid = mid - c;
        end
        if (tl) begin
            m_addr[m_n] = cur; m_burst[m_n] = 1'b0; m_blen[m_n] = 4'd0; m_n++;
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // entered at a falling edge where command k must be presented
    task automatic take_cmd(input int k, input bit stall);
        check("R2/R3/R4/R5/R6/R12 cmd_valid", 64'(cmd_valid), 64'd1);
        check("R2/R3/R7/R8 cmd_addr", 64'(cmd_addr), 64'(m_addr[k]));
        check("R5/R6 cmd_burst", 64'(cmd_burst), 64'(m_burst[k]));
        check("R5 cmd_blen", 64'(cmd_blen), 64'(m_blen[k]));
        if (stall) begin
            cmd_ready = 1'b0;
            req_valid = 1'b1;
            req_len = 8'd3;
            req_addr = 32'hDEAD_0000;
            req_first_strb = 4'hF;
            req_last_strb = 4'hF;
            @(negedge clk);
            req_valid = 1'b0;
            check("R11 req_ready while busy", 64'(req_ready), 64'd0);
            check("R10 held addr", 64'(cmd_addr), 64'(m_addr[k]));
            check("R10 held burst/blen", 64'({cmd_valid, cmd_burst, cmd_blen}),
                  64'({1'b1, m_burst[k], m_blen[k]}));
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
    endtask

    task automatic run_vec(input int i, input bit stall_odd);
        vec_t v;
        v = VECS[i];
        build_model(v);
        check("R11 idle before request", 64'(req_ready), 64'd1);
        req_addr = v.addr; req_len = v.len;
        req_first_strb = v.fs; req_last_strb = v.ls;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 busy after accept", 64'(req_ready), 64'd0);
        for (int k = 0; k < int'(v.n); k++) begin
            take_cmd(k, stall_odd && (k % 2 == 0));
        end
        // R9: command count matches the table
        check("R9/R12 no extra command", 64'(cmd_valid), 64'd0);
        check("R11 ready after last ack", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset req_ready", 64'(req_ready), 64'd1);
        check("R1 reset cmd_valid", 64'(cmd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset cmd_valid", 64'(cmd_valid), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i, 1'b0);
        for (int i = 0; i < NV; i++) run_vec(i, 1'b1);

        // directed: reset in the middle of a long series
        build_model(VECS[10]);
        req_addr = VECS[10].addr; req_len = VECS[10].len;
        req_first_strb = VECS[10].fs; req_last_strb = VECS[10].ls;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        take_cmd(0, 1'b0);
        take_cmd(1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-burst reset req_ready", 64'(req_ready), 64'd1);
        check("R1 mid-burst reset cmd_valid", 64'(cmd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(7, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule